// File: doc/BRIEF.md
# Supply level detector measurement sequencer

This block is the digital control for an on-chip supply-voltage check. Software picks one of eight detection thresholds through a level register and then writes a start request into a control register. The block waits for the next rising edge of a slow prescaler tap, which is nominally 256 Hz. It enables an external analog comparator for exactly the high phase of that tap. On the last enabled cycle it captures the comparator output and reports it as the result bit.

The prescaler tap is asynchronous to the system clock, so it passes through a two-flop synchroniser and an edge detector first. The sleep input inhibits the detector. A start request made during sleep is dropped, and sleep arriving while a measurement is pending or running cancels it. In both cases the last valid result is kept.

Top module: `supply_lvl_seq`

## Requirements
- R1: After reset, both register addresses read 0, `cmp_en_o` is 0 and `level_o` is 0.
- R2: Address 0 is the control register. Bit 0 is the start request: writing 1 requests a measurement, and the bit always reads 0. Bit 1 is busy, bit 2 is the result and bit 3 reads 0. Address 1 holds the level code in bits 2:0, and bit 3 reads 0.
- R3: Busy reads 1 from the first cycle after an accepted start write. It stays 1 until the clock edge at which `cmp_en_o` falls.
- R4: Number the clock edges from the first edge that samples `tap_i` high. `cmp_en_o` rises after the third of these edges. It stays high for exactly as many cycles as `tap_i` stayed high.
- R5: The result bit takes the value of `cmp_i` on the last cycle `cmp_en_o` is high. 1 means the supply is below the selected level and 0 means it is above. Busy clears at that same edge.
- R6: While busy is 1, the result bit keeps the previous measurement's value.
- R7: A start written while busy is ignored. It does not extend the current measurement and does not queue a new one.
- R8: A start written while `sleep_i` is 1 is ignored. If `sleep_i` is 1 while a measurement is pending or active, the measurement is cancelled: busy and `cmp_en_o` are 0 one cycle later, and the result is unchanged.
- R9: `level_o` drives the level register. Writes to the level register are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_i | input | 1 | Slow prescaler tap, asynchronous |
| sleep_i | input | 1 | Chip sleep indication |
| cmp_i | input | 1 | Comparator output, 1 = supply below level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 4 | Register write data |
| rdata_o | output | 4 | Register read data, combinational from addr_i |
| cmp_en_o | output | 1 | Comparator enable |
| level_o | output | 3 | Level code to the reference ladder |

## Verification
A start write shows as busy in the cycle after its write edge. The comparator enable rises two cycles after the first clock edge that samples the tap high. It falls two cycles after the tap drops, and the result and the cleared busy appear at that same edge. A sleep-driven cancellation is visible one cycle after sleep is seen. The bench drives inputs on the falling clock edge and counts falling edges from the tap change. It records the first and last cycle of each enable window and the busy value at the boundary cycles, and compares these with offsets derived from the two synchroniser stages. Expected results come from a bench-side threshold model swept over every level code and a range of supply values.

// File: rtl/supply_lvl_pkg.sv
package supply_lvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_MEAS = 2'd2
  } meas_state_e;

  localparam int unsigned CTL_START  = 0;
  localparam int unsigned CTL_BUSY   = 1;
  localparam int unsigned CTL_RESULT = 2;
  localparam int unsigned ADDR_CTL   = 0;
  localparam int unsigned ADDR_LVL   = 1;
endpackage

// File: rtl/tap_edge_sync.sv
module tap_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tap_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], tap_i};
  end

  assign rise_o = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign fall_o = ~sh_q[SH_W-2] & sh_q[SH_W-1];
endmodule

// File: rtl/meas_ctrl.sv
module meas_ctrl
  import supply_lvl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sleep_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic cmp_i,
  output logic busy_o,
  output logic en_o,
  output logic result_o
);
  meas_state_e state_q, state_d;
  logic        res_q, res_d;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: if (start_i && !sleep_i) state_d = ST_PEND;
      ST_PEND: begin
        if (sleep_i)     state_d = ST_IDLE;
        else if (rise_i) state_d = ST_MEAS;
      end
      ST_MEAS: begin
        if (sleep_i) state_d = ST_IDLE;
        else if (fall_i) begin
          state_d = ST_IDLE;
          res_d   = cmp_i;  // last enabled cycle
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign en_o     = (state_q == ST_MEAS);
  assign result_o = res_q;

  assert_busy_from_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i) && !$past(sleep_i));

  assert_open_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(rise_i));

  assert_result_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_o && fall_i && !sleep_i) |=> $stable(result_o));

  assert_sleep_cancels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !busy_o && !en_o);

  assert_start_ignored_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PEND) && !rise_i && !sleep_i |=> state_q == ST_PEND);
endmodule

// File: rtl/lvl_regs.sv
module lvl_regs
  import supply_lvl_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              result_i,
  output logic              start_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(ADDR_LVL);

  logic [LVL_W-1:0] level_q;
  logic             lvl_we;

  assign start_o = wr_en_i && (addr_i == A_CTL) && wdata_i[CTL_START];
  assign lvl_we  = wr_en_i && (addr_i == A_LVL) && !busy_i;  // frozen during measurement

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= '0;
    else if (lvl_we) level_q <= wdata_i[LVL_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTL) begin
      rdata_o[CTL_BUSY]   = busy_i;
      rdata_o[CTL_RESULT] = result_i;
    end else if (addr_i == A_LVL) begin
      rdata_o[LVL_W-1:0] = level_q;
    end
  end

  assign level_o = level_q;

  assert_level_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(level_o));

  assert_start_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTL) |-> !rdata_o[CTL_START]);
endmodule

// File: rtl/supply_lvl_seq.sv
module supply_lvl_seq #(
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tap_i,
  input  logic              sleep_i,
  input  logic              cmp_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cmp_en_o,
  output logic [LVL_W-1:0]  level_o
);
  logic rise, fall, start, busy, result;

  tap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_i (tap_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  meas_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .sleep_i (sleep_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .cmp_i   (cmp_i),
    .busy_o  (busy),
    .en_o    (cmp_en_o),
    .result_o(result)
  );

  lvl_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .result_i(result),
    .start_o (start),
    .level_o (level_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/supply_lvl_seq_bench.sv
module supply_lvl_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tap_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [0:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic       cmp_en_o;
  logic [2:0] level_o;
  logic       cmp_i;
  int         supply = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;

  always #5 clk_i = ~clk_i;

  function automatic int thr(input logic [2:0] l);
    return 150 + 25 * int'(l);
  endfunction

  assign cmp_i = cmp_en_o && (supply < thr(level_o));

  supply_lvl_seq u_supply_lvl_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tap_i(tap_i), .sleep_i(sleep_i), .cmp_i(cmp_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .cmp_en_o(cmp_en_o), .level_o(level_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [3:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  // tap high for h clock edges; records enable window and busy at its boundary
  task automatic window(input int h, output int cnt, output int first, output int last,
                        output int busy_in, output int busy_out);
    logic [3:0] d;
    cnt = 0; first = -1; last = -1; busy_in = -1; busy_out = -1;
    tap_i = 1'b1;
    for (int i = 0; i < h + 5; i++) begin
      @(negedge clk_i);
      if (i == h - 1) tap_i = 1'b0;
      if (cmp_en_o) begin cnt++; if (first < 0) first = i; last = i; end
      rd(1'b0, d);
      if (i == h + 1) busy_in = int'(d[1]);
      if (i == h + 2) busy_out = int'(d[1]);
    end
  endtask

  task automatic meas(input logic [2:0] lvl, input int sup, input int pend, input int h,
                      inout logic prev);
    logic [3:0] d;
    int cnt, first, last, bi, bo;
    logic exp;
    wr(1'b1, {1'b0, lvl});
    chk("R9 level_o", int'(level_o), int'(lvl));
    supply = sup;
    exp = (sup < thr(lvl));
    wr(1'b0, 4'h1);
    rd(1'b0, d);
    chk("R3 busy after start", int'(d[1]), 1);
    chk("R2 start reads 0", int'(d[0]), 0);
    chk("R6 result held", int'(d[2]), int'(prev));
    repeat (pend) @(negedge clk_i);
    rd(1'b0, d);
    chk("R6 result held pending", int'(d[2]), int'(prev));
    window(h, cnt, first, last, bi, bo);
    chk("R4 window start", first, 2);
    chk("R4 window length", cnt, h);
    chk("R3 busy last cycle", bi, 1);
    chk("R5 busy cleared", bo, 0);
    rd(1'b0, d);
    chk("R5 result", int'(d[2]), int'(exp));
    prev = exp;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    logic prev;
    int cnt, first, last, bi, bo;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(1'b0, d); chk("R1 ctl after reset", int'(d), 0);
    rd(1'b1, d); chk("R1 level after reset", int'(d), 0);
    chk("R1 cmp_en after reset", int'(cmp_en_o), 0);
    chk("R1 level_o after reset", int'(level_o), 0);

    wr(1'b1, 4'hD);
    rd(1'b1, d); chk("R2 level readback bit3 zero", int'(d), 5);
    rd(1'b0, d); chk("R2 ctl idle", int'(d), 0);

    // tap pulse with no request opens nothing
    window(3, cnt, first, last, bi, bo);
    chk("R4 no window without start", cnt, 0);

    prev = 1'b0;
    for (int l = 0; l < 8; l++)
      for (int j = 0; j < 8; j++)
        meas(3'(l), 155 + 25 * j, (l + j) % 3, 1 + (l + 2 * j) % 5, prev);

    // R7: start during active window is ignored
    wr(1'b1, 4'h0); supply = 100;
    wr(1'b0, 4'h1);
    tap_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R7 window active", int'(cmp_en_o), 1);
    wr(1'b0, 4'h1);
    // R9: level write while busy
    wr(1'b1, 4'h6);
    chk("R9 level frozen while busy", int'(level_o), 0);
    tap_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rd(1'b0, d);
    chk("R7 busy clears", int'(d[1]), 0);
    chk("R5 result below", int'(d[2]), 1);
    window(3, cnt, first, last, bi, bo);
    chk("R7 no queued window", cnt, 0);
    wr(1'b1, 4'h6);
    chk("R9 level write when idle", int'(level_o), 6);

    // R8: start during sleep
    supply = 500;
    sleep_i = 1'b1;
    wr(1'b0, 4'h1);
    rd(1'b0, d); chk("R8 start in sleep ignored", int'(d[1]), 0);
    window(3, cnt, first, last, bi, bo);
    chk("R8 no window in sleep", cnt, 0);
    sleep_i = 1'b0;

    // R8: cancel while pending
    wr(1'b0, 4'h1);
    sleep_i = 1'b1;
    @(negedge clk_i);
    rd(1'b0, d); chk("R8 pending cancelled", int'(d[1]), 0);
    sleep_i = 1'b0;
    window(3, cnt, first, last, bi, bo);
    chk("R8 no window after cancel", cnt, 0);
    rd(1'b0, d); chk("R8 result kept pending", int'(d[2]), 1);

    // R8: cancel while active
    wr(1'b0, 4'h1);
    tap_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 window open", int'(cmp_en_o), 1);
    sleep_i = 1'b1;
    @(negedge clk_i);
    chk("R8 enable dropped", int'(cmp_en_o), 0);
    rd(1'b0, d); chk("R8 busy dropped", int'(d[1]), 0);
    tap_i = 1'b0;
    repeat (4) @(negedge clk_i);
    sleep_i = 1'b0;
    rd(1'b0, d); chk("R8 result kept active", int'(d[2]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule